// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Core

This block is a small 32-bit processor that completes one instruction in every clock cycle. It has a program counter, a byte-addressed instruction store, a 32-entry register bank with two read ports and one write port, an arithmetic unit, a sign extender for 16-bit offsets, branch-target logic, a byte-addressed data store and an instruction decoder. Nine instructions are decoded: five logic/arithmetic register operations, a signed set-on-less-than, a word load, a word store and a branch on register equality. Anything else executes as a no-op.

The only ports are a clock, an active-low reset and a set of debug taps. The taps show the address of the instruction currently executing and, in the same cycle, any register write that instruction performs. Both stores are plain byte arrays that a testbench may fill before reset is released. Addresses are assumed word-aligned.

Top module: `sc_core`

## Requirements
- R1: While `rst_n` is low the program counter is 0. It clears asynchronously, without waiting for a clock edge.
- R2: For every instruction other than a taken branch, the program counter advances by 4 on each rising clock edge.
- R3: Both stores are byte-addressed and little-endian. A word read at address A returns byte A in bits 7:0, A+1 in 15:8, A+2 in 23:16 and A+3 in 31:24.
- R4: A load (opcode 0x23) reads the word at register rs (bits 25:21) plus the 16-bit offset (bits 15:0) sign-extended to 32 bits. It writes that word to register rt (bits 20:16).
- R5: A store (opcode 0x2B) writes register rt to the data store at rs plus the sign-extended offset on the rising clock edge. A later load from that address returns the value, and the store itself writes no register.
- R6: Register operations use opcode 0 and write the result to rd (bits 15:11). The funct field (bits 5:0) selects the operation: 0x20 is add, 0x22 is rs minus rt, 0x24 is AND, 0x25 is OR and 0x27 is NOR.
- R7: Funct 0x2A writes 1 to rd when rs is less than rt as signed 32-bit numbers, and 0 otherwise.
- R8: Register 0 always reads as zero. A write aimed at it is dropped and does not appear on the write tap.
- R9: A branch (opcode 0x04) compares rs and rt by subtraction. When they are equal, the next PC is PC+4 plus the sign-extended offset shifted left by 2; otherwise it is PC+4. A branch writes no register.
- R10: An unknown opcode, or an unknown funct under opcode 0, writes no register and no memory, and the PC advances by 4.
- R11: `dbg_wr_en` is high in exactly the cycles whose instruction writes a register. In those cycles `dbg_wr_idx` and `dbg_wr_data` give the destination and the value, and the register holds that value after the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the program counter |
| dbg_pc | output | 32 | Address of the instruction executing this cycle |
| dbg_wr_en | output | 1 | The current instruction writes a register at the next edge |
| dbg_wr_idx | output | 5 | Destination register of that write |
| dbg_wr_data | output | 32 | Value being written |

## Verification
The taps are combinational views of the instruction at the current PC, so a write is due in the same cycle its instruction is fetched. Its effect on the PC and on the stored state is due one rising edge later. The bench samples 1 ns after each falling edge: each sample shows one instruction's write, and the PC that the previous edge produced. A value that passes through a register or the data store is checked by a later instruction that reads it back, sampled in that instruction's own cycle. The effect of asynchronous reset on the PC is sampled 1 ns after reset is asserted, with no edge in between.

// File: rtl/sc_pkg.sv
package sc_pkg;
   localparam int DW    = 32;
   localparam int NREG  = 32;
   localparam int RW    = $clog2(NREG);
   localparam int OPW   = 6;
   localparam int IMMW  = 16;

   localparam logic [OPW-1:0] OP_REG   = 6'h00;
   localparam logic [OPW-1:0] OP_LOAD  = 6'h23;
   localparam logic [OPW-1:0] OP_STORE = 6'h2B;
   localparam logic [OPW-1:0] OP_BEQ   = 6'h04;

   localparam logic [5:0] FN_ADD = 6'h20;
   localparam logic [5:0] FN_SUB = 6'h22;
   localparam logic [5:0] FN_AND = 6'h24;
   localparam logic [5:0] FN_OR  = 6'h25;
   localparam logic [5:0] FN_NOR = 6'h27;
   localparam logic [5:0] FN_SLT = 6'h2A;

   typedef enum logic [2:0] {
      ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_NOR, ALU_SLT
   } alu_op_e;

   typedef struct packed {
      logic    reg_we;
      logic    dst_is_rd;
      logic    b_is_imm;
      logic    mem_we;
      logic    wb_from_mem;
      logic    branch;
      alu_op_e alu_op;
   } ctrl_t;
endpackage

// File: rtl/sc_decode.sv
module sc_decode
   import sc_pkg::*;
(
   input  logic [OPW-1:0] opcode,
   input  logic [5:0]     funct,
   output ctrl_t          ctrl
);
   always_comb begin
      ctrl = '{reg_we: 1'b0, dst_is_rd: 1'b0, b_is_imm: 1'b0, mem_we: 1'b0,
               wb_from_mem: 1'b0, branch: 1'b0, alu_op: ALU_ADD};
      unique case (opcode)
         OP_REG: begin
            ctrl.dst_is_rd = 1'b1;
            ctrl.reg_we    = 1'b1;
            case (funct)
               FN_ADD:  ctrl.alu_op = ALU_ADD;
               FN_SUB:  ctrl.alu_op = ALU_SUB;
               FN_AND:  ctrl.alu_op = ALU_AND;
               FN_OR:   ctrl.alu_op = ALU_OR;
               FN_NOR:  ctrl.alu_op = ALU_NOR;
               FN_SLT:  ctrl.alu_op = ALU_SLT;
               default: ctrl.reg_we = 1'b0;
            endcase
         end
         OP_LOAD: begin
            ctrl.reg_we      = 1'b1;
            ctrl.b_is_imm    = 1'b1;
            ctrl.wb_from_mem = 1'b1;
         end
         OP_STORE: begin
            ctrl.mem_we   = 1'b1;
            ctrl.b_is_imm = 1'b1;
         end
         OP_BEQ: begin
            ctrl.branch = 1'b1;
            ctrl.alu_op = ALU_SUB;
         end
         default: ;
      endcase
   end

   always_comb begin
      AST_ONE_EFFECT: assert ($onehot0({ctrl.reg_we, ctrl.mem_we, ctrl.branch})); // R10
   end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
   import sc_pkg::*;
#(
   parameter int W = DW
) (
   input  alu_op_e      op,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] y,
   output logic         zero
);
   localparam int SW = W;

   initial begin
      if (W < 2) $error("sc_alu: width must be at least 2");
   end

   logic [W-1:0] diff;
   logic         lt_signed;

   assign diff      = a - b;
   assign lt_signed = $signed(a[SW-1:0]) < $signed(b[SW-1:0]);

   always_comb begin
      unique case (op)
         ALU_ADD: y = a + b;
         ALU_SUB: y = diff;
         ALU_AND: y = a & b;
         ALU_OR:  y = a | b;
         ALU_NOR: y = ~(a | b);
         ALU_SLT: y = {{(W-1){1'b0}}, lt_signed};
         default: y = '0;
      endcase
   end

   assign zero = (y == '0);

   always_comb begin
      if (op == ALU_SUB) begin
         AST_SUB_ZERO_EQ: assert (zero == (a == b)); // R9
      end
   end
endmodule

// File: rtl/sc_regbank.sv
module sc_regbank
   import sc_pkg::*;
#(
   parameter int W    = DW,
   parameter int N    = NREG,
   localparam int AW  = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] ra_a,
   input  logic [AW-1:0] ra_b,
   output logic [W-1:0]  rd_a,
   output logic [W-1:0]  rd_b,
   input  logic          we,
   input  logic [AW-1:0] wa,
   input  logic [W-1:0]  wd
);
   generate
      if ((1 << AW) != N) begin : g_bad_n
         $error("sc_regbank: register count must be a power of two");
      end
   endgenerate

   logic [W-1:0] regs [N];

   always_ff @(posedge clk) begin
      if (we && wa != '0) regs[wa] <= wd;
   end

   assign rd_a = (ra_a == '0) ? '0 : regs[ra_a];
   assign rd_b = (ra_b == '0) ? '0 : regs[ra_b];

   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (we && wa != '0) |=> (regs[$past(wa)] == $past(wd))); // R11
endmodule

// File: rtl/sc_bytemem.sv
module sc_bytemem
   import sc_pkg::*;
#(
   parameter int DEPTH    = 256,
   parameter bit WRITABLE = 1'b1,
   localparam int AW      = $clog2(DEPTH),
   localparam int NB      = DW / 8
) (
   input  logic          clk,
   input  logic [DW-1:0] addr,
   input  logic          we,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);
   generate
      if ((1 << AW) != DEPTH || DEPTH < NB) begin : g_bad_depth
         $error("sc_bytemem: depth must be a power of two of at least one word");
      end
   endgenerate

   logic [7:0]    mem [DEPTH];
   logic [AW-1:0] lane_idx [NB];
   logic [DW-1:0] unused_addr_hi;

   assign unused_addr_hi = addr;

   initial begin
      for (int i = 0; i < DEPTH; i++) mem[i] = 8'h00;
   end

   for (genvar k = 0; k < NB; k++) begin : g_lane
      assign lane_idx[k]      = addr[AW-1:0] + AW'(k);
      assign rdata[8*k +: 8]  = mem[lane_idx[k]];
   end

   generate
      if (WRITABLE) begin : g_wr
         always_ff @(posedge clk) begin
            if (we) begin
               for (int k = 0; k < NB; k++) mem[lane_idx[k]] <= wdata[8*k +: 8];
            end
         end
      end else begin : g_ro
         logic unused_wr;
         assign unused_wr = we ^ (^wdata);
      end
   endgenerate
endmodule

// File: rtl/sc_core.sv
module sc_core
   import sc_pkg::*;
#(
   parameter int IMEM_BYTES = 256,
   parameter int DMEM_BYTES = 256
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic [31:0]   dbg_pc,
   output logic          dbg_wr_en,
   output logic [4:0]    dbg_wr_idx,
   output logic [31:0]   dbg_wr_data
);
   localparam logic [DW-1:0] STEP = DW'(DW / 8);

   initial begin
      if (DMEM_BYTES < 256) $error("sc_core: data store needs at least 256 bytes");
   end

   logic [DW-1:0] pc_q, pc_next, pc_plus;
   logic [DW-1:0] instr;
   logic [OPW-1:0] opcode;
   logic [RW-1:0]  rs, rt, rd, waddr;
   logic [DW-1:0]  imm_sx, rs_val, rt_val, alu_b, alu_y, mem_rd, wb_data;
   logic           alu_zero, br_take, wr_fire;
   logic [4:0]     unused_shamt;
   ctrl_t          ctrl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pc_q <= '0;
      else        pc_q <= pc_next;
   end

   sc_bytemem #(.DEPTH(IMEM_BYTES), .WRITABLE(1'b0)) u_imem (
      .clk(clk), .addr(pc_q), .we(1'b0), .wdata('0), .rdata(instr)
   );

   assign opcode       = instr[31:26];
   assign rs           = instr[25:21];
   assign rt           = instr[20:16];
   assign rd           = instr[15:11];
   assign unused_shamt = instr[10:6];
   assign imm_sx       = {{(DW-IMMW){instr[IMMW-1]}}, instr[IMMW-1:0]};

   sc_decode u_dec (.opcode(opcode), .funct(instr[5:0]), .ctrl(ctrl));

   assign waddr   = ctrl.dst_is_rd ? rd : rt;
   assign wr_fire = ctrl.reg_we && (waddr != '0);

   sc_regbank u_rf (
      .clk(clk), .rst_n(rst_n), .ra_a(rs), .ra_b(rt), .rd_a(rs_val), .rd_b(rt_val),
      .we(wr_fire), .wa(waddr), .wd(wb_data)
   );

   assign alu_b = ctrl.b_is_imm ? imm_sx : rt_val;

   sc_alu u_alu (.op(ctrl.alu_op), .a(rs_val), .b(alu_b), .y(alu_y), .zero(alu_zero));

   sc_bytemem #(.DEPTH(DMEM_BYTES), .WRITABLE(1'b1)) u_dmem (
      .clk(clk), .addr(alu_y), .we(ctrl.mem_we), .wdata(rt_val), .rdata(mem_rd)
   );

   assign wb_data = ctrl.wb_from_mem ? mem_rd : alu_y;
   assign br_take = ctrl.branch && alu_zero;
   assign pc_plus = pc_q + STEP;
   assign pc_next = br_take ? (pc_plus + (imm_sx << 2)) : pc_plus;

   assign dbg_pc      = pc_q;
   assign dbg_wr_en   = wr_fire;
   assign dbg_wr_idx  = waddr;
   assign dbg_wr_data = wb_data;

   AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !br_take |=> (pc_q == $past(pc_q) + 32'd4)); // R2
   AST_PC_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
      br_take |=> (pc_q == $past(pc_q) + 32'd4 + ($past(imm_sx) << 2))); // R9
   AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      pc_q[1:0] == 2'b00); // R2
   AST_NO_R0_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_wr_en |-> (dbg_wr_idx != 5'd0)); // R8
endmodule

// File: tb/sc_core_test.sv
`timescale 1ns/1ps
module sc_core_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] dbg_pc, dbg_wr_data;
   logic        dbg_wr_en;
   logic [4:0]  dbg_wr_idx;
   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   sc_core uut (.clk(clk), .rst_n(rst_n), .dbg_pc(dbg_pc), .dbg_wr_en(dbg_wr_en),
                .dbg_wr_idx(dbg_wr_idx), .dbg_wr_data(dbg_wr_data));

   function automatic logic [31:0] enc_r(input int s, input int t, input int d, input logic [5:0] fn);
      return {6'h00, 5'(s), 5'(t), 5'(d), 5'h00, fn};
   endfunction
   function automatic logic [31:0] enc_i(input logic [5:0] op, input int s, input int t, input int off);
      return {op, 5'(s), 5'(t), 16'(off)};
   endfunction

   task automatic put_i(input int a, input logic [31:0] w);
      for (int k = 0; k < 4; k++) uut.u_imem.mem[a+k] = w[8*k +: 8];
   endtask
   task automatic put_d(input int a, input logic [31:0] w);
      for (int k = 0; k < 4; k++) uut.u_dmem.mem[a+k] = w[8*k +: 8];
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // check one instruction cycle, then move to the next sample point
   task automatic step(input string req, input logic [31:0] pc, input bit we,
                       input int idx, input logic [31:0] data);
      chk({req, " pc"}, dbg_pc, pc);
      chk({req, " wr_en"}, {31'd0, dbg_wr_en}, {31'd0, we});
      if (we) begin
         chk({req, " wr_idx"}, {27'd0, dbg_wr_idx}, 32'(idx));
         chk({req, " wr_data"}, dbg_wr_data, data);
      end
      @(negedge clk); #1;
   endtask

   task automatic t_reset;
      chk("R1 pc in reset", dbg_pc, 32'd0);
      @(negedge clk); rst_n = 1'b1; #1;
   endtask

   task automatic t_loads;   // R4 R3 R11
      step("R4 lw r1", 32'd0, 1, 1, 32'd5);
      step("R4 lw r2", 32'd4, 1, 2, 32'd7);
      step("R4 lw r3", 32'd8, 1, 3, 32'hFFFF_FFFD);
   endtask

   task automatic t_alu;     // R6 R7 R2
      step("R6 add", 32'd12, 1, 4, 32'd12);
      step("R6 sub", 32'd16, 1, 5, 32'hFFFF_FFFE);
      step("R6 and", 32'd20, 1, 6, 32'd5);
      step("R6 or",  32'd24, 1, 7, 32'd7);
      step("R6 nor", 32'd28, 1, 8, 32'hFFFF_FFF8);
      step("R7 slt neg<pos", 32'd32, 1, 9, 32'd1);
      step("R7 slt pos<neg", 32'd36, 1, 10, 32'd0);
   endtask

   task automatic t_zero_reg;
      step("R8 write r0 dropped", 32'd40, 0, 0, 32'd0);
   endtask

   task automatic t_store_load;
      step("R5 sw no reg write", 32'd44, 0, 0, 32'd0);
      step("R5 lw after sw", 32'd48, 1, 11, 32'd12);
      step("R3 little-endian word", 32'd52, 1, 12, 32'h1234_5678);
      step("R4 negative offset", 32'd56, 1, 13, 32'hFFFF_FFFD);
   endtask

   task automatic t_noop;
      step("R10 bad opcode", 32'd60, 0, 0, 32'd0);
      step("R10 bad funct", 32'd64, 0, 0, 32'd0);
   endtask

   task automatic t_branch;
      step("R9 beq not taken", 32'd68, 0, 0, 32'd0);
      step("R9 beq taken fwd", 32'd72, 0, 0, 32'd0);
      step("R9 target", 32'd84, 0, 0, 32'd0);
      step("R9 self loop", 32'd84, 0, 0, 32'd0);
      step("R8 r0 reads zero", 32'd84, 0, 0, 32'd0);
   endtask

   task automatic t_async_reset;
      #2 rst_n = 1'b0; #1;
      chk("R1 async clear", dbg_pc, 32'd0);
      @(negedge clk); @(negedge clk);
      chk("R1 held in reset", dbg_pc, 32'd0);
      rst_n = 1'b1; #1;
      step("R1 restart", 32'd0, 1, 1, 32'd5);
      step("R2 restart step", 32'd4, 1, 2, 32'd7);
   endtask

   initial begin
      #1;
      put_d(0, 32'd5);
      put_d(4, 32'd7);
      put_d(8, 32'hFFFF_FFFD);
      uut.u_dmem.mem[12] = 8'h78; uut.u_dmem.mem[13] = 8'h56;
      uut.u_dmem.mem[14] = 8'h34; uut.u_dmem.mem[15] = 8'h12;
      put_i(0,  enc_i(6'h23, 0, 1, 0));
      put_i(4,  enc_i(6'h23, 0, 2, 4));
      put_i(8,  enc_i(6'h23, 0, 3, 8));
      put_i(12, enc_r(1, 2, 4, 6'h20));
      put_i(16, enc_r(1, 2, 5, 6'h22));
      put_i(20, enc_r(1, 2, 6, 6'h24));
      put_i(24, enc_r(1, 2, 7, 6'h25));
      put_i(28, enc_r(1, 2, 8, 6'h27));
      put_i(32, enc_r(3, 1, 9, 6'h2A));
      put_i(36, enc_r(1, 3, 10, 6'h2A));
      put_i(40, enc_r(1, 2, 0, 6'h20));
      put_i(44, enc_i(6'h2B, 0, 4, 16));
      put_i(48, enc_i(6'h23, 0, 11, 16));
      put_i(52, enc_i(6'h23, 0, 12, 12));
      put_i(56, enc_i(6'h23, 4, 13, -4));
      put_i(60, enc_i(6'h3F, 1, 14, 0));
      put_i(64, enc_r(1, 2, 15, 6'h21));
      put_i(68, enc_i(6'h04, 1, 2, 5));
      put_i(72, enc_i(6'h04, 6, 1, 2));
      put_i(76, enc_r(1, 1, 14, 6'h20));
      put_i(80, enc_r(1, 1, 14, 6'h20));
      put_i(84, enc_i(6'h04, 0, 0, -1));
      t_reset();
      t_loads();
      t_alu();
      t_zero_reg();
      t_store_load();
      t_noop();
      t_branch();
      t_async_reset();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #100us;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule